// File: doc/BRIEF.md
# Process-ID Address Protection Unit

This unit sits between a CPU's address generation and its memory, and turns 16-bit user addresses into 24-bit physical ones. The top 8 bits of every physical address are a process ID held inside the unit. Each user process therefore lives in its own 64KB bank and cannot name any other bank. ID zero belongs to the operating system.

Ordinary accesses supply only a 16-bit offset and a displacement. The unit adds them modulo 64K and prefixes the current ID. Any upper bits the CPU presents are ignored. Full-width accesses and process-ID writes are privileged. They are honoured only while the upper byte of the program counter is zero; otherwise they are dropped and a violation pulse is raised.

An interrupt or OS call forces the current ID to zero and remembers the interrupted user ID. A return from the OS restores the remembered ID. The scheduler picks the next process by writing a new remembered ID, which takes effect at the following return. A physical bank at or above the installed bank count is faulted and the access is dropped.

Accesses flow as a valid/ready stream. The unit accepts an access when the memory side is ready, or at once when the access is dropped. While the memory side stalls a valid access, the upstream side must hold the access unchanged.

Top module: `pid_guard`

## Requirements
- R1: After reset the current ID is 0, the remembered ID is 0 (a return right after reset leaves the ID at 0), and `priv_viol_o`, `bank_fault_o` and `mem_valid_o` are low.
- R2: An ordinary access (`acc_full_i`=0) presents `mem_addr_o` = {current ID, (`acc_addr_i`[15:0] + `acc_disp_i`) mod 2^16}. Bits [23:16] of `acc_addr_i` have no effect, and the sum never carries into bit 16.
- R3: `os_enter_i` makes `pid_o` 0 from the next cycle on. It takes priority over `os_return_i` in the same cycle. If the current ID was nonzero, that ID becomes the remembered ID.
- R4: `os_return_i` (without `os_enter_i`) loads the remembered ID into `pid_o` in the next cycle. A nested entry made while the ID is already 0 keeps the remembered ID unchanged.
- R5: A full-width access (`acc_full_i`=1) with `pc_bank_i`=0 presents `mem_addr_o` = (`acc_addr_i` + zero-extended `acc_disp_i`) mod 2^24. The carry may cross into the bank byte.
- R6: A full-width access or an ID write attempted while `pc_bank_i`≠0 is not performed. For an access, `mem_valid_o` stays 0 and `acc_ready_o` is 1 in that cycle. For a write, the remembered ID is unchanged. `priv_viol_o` is 1 in the following cycle only.
- R7: `priv_grant_o` equals `priv_req_i` when `pc_bank_i`=0 and is 0 otherwise. A refused request raises `priv_viol_o` in the next cycle.
- R8: A granted ID write (`pid_wr_i` with `pc_bank_i`=0) sets the remembered ID to `pid_wdata_i`. `pid_o` is unchanged until the next return.
- R9: An access whose physical bank is at or above BANKS (default 8, leaving 7 user IDs) is faulted. `mem_valid_o` is 0 and `acc_ready_o` is 1 in that cycle, and `bank_fault_o` is 1 in the next cycle only.
- R10: While `mem_valid_o`=1 and `mem_ready_i`=0, `acc_ready_o` is 0. Otherwise, a valid access is accepted in the cycle that `mem_ready_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_bank_i | input | 8 | Upper byte of the CPU program counter |
| os_enter_i | input | 1 | Interrupt or OS-call entry event |
| os_return_i | input | 1 | Return from OS to user event |
| priv_req_i | input | 1 | Privileged full-width instruction flag |
| priv_grant_o | output | 1 | Privileged instruction may execute |
| pid_wr_i | input | 1 | Request to write the remembered process ID |
| pid_wdata_i | input | 8 | Process ID to write |
| acc_valid_i | input | 1 | Access request valid |
| acc_ready_o | output | 1 | Access accepted or dropped this cycle |
| acc_full_i | input | 1 | Access uses the full 24-bit address |
| acc_addr_i | input | 24 | Address register value |
| acc_disp_i | input | 16 | Displacement added to the address |
| mem_valid_o | output | 1 | Physical access valid |
| mem_ready_i | input | 1 | Memory side ready |
| mem_addr_o | output | 24 | Physical address |
| pid_o | output | 8 | Current process ID |
| priv_viol_o | output | 1 | Privilege violation pulse |
| bank_fault_o | output | 1 | Out-of-range bank pulse |

## Verification
The assertions take for granted that `os_enter_i` and `os_return_i` do not arrive while a valid access is stalled, since either would change the bank under a held address. They also take for granted that the upstream side keeps a stalled access unchanged until it is accepted. The stimulus keeps within both. It raises a control event only in cycles with no access pending, and it holds every access field constant across the stalled cycles of the back-pressure test. It drives all inputs at the falling edge, so pulses and ID changes are read one full cycle after the event that caused them.

// File: rtl/pid_guard_pkg.sv
package pid_guard_pkg;

  // Mode event decoded from the entry and return strobes (entry wins).
  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_ENTER  = 2'd1,
    EV_RETURN = 2'd2
  } pid_ev_e;

  function automatic pid_ev_e decode_ev(input logic enter, input logic ret);
    if (enter)    return EV_ENTER;
    else if (ret) return EV_RETURN;
    else          return EV_NONE;
  endfunction

endpackage

// File: rtl/pid_state.sv
module pid_state
  import pid_guard_pkg::*;
#(
  parameter int PID_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             os_enter,
  input  logic             os_return,
  input  logic             wr_grant,
  input  logic [PID_W-1:0] wr_pid,
  output logic [PID_W-1:0] cur_pid,
  output logic [PID_W-1:0] resume_pid
);

  pid_ev_e ev;
  assign ev = decode_ev(os_enter, os_return);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_pid    <= '0;
      resume_pid <= '0;
    end else begin
      unique case (ev)
        EV_ENTER: begin
          cur_pid <= '0;
          if (cur_pid != '0) resume_pid <= cur_pid;
          else if (wr_grant) resume_pid <= wr_pid;
        end
        EV_RETURN: begin
          cur_pid <= resume_pid;
          if (wr_grant) resume_pid <= wr_pid;
        end
        default: begin
          if (wr_grant) resume_pid <= wr_pid;
        end
      endcase
    end
  end

  AST_ENTER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    os_enter |=> (cur_pid == '0)); // R3

  AST_ENTER_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    (os_enter && cur_pid != '0) |=> (resume_pid == $past(cur_pid))); // R3

  AST_RETURN_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    (os_return && !os_enter) |=> (cur_pid == $past(resume_pid))); // R4

  AST_PID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!os_enter && !os_return) |=> $stable(cur_pid)); // R8

endmodule

// File: rtl/priv_check.sv
module priv_check #(
  parameter int PID_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PID_W-1:0] pc_bank,
  input  logic             priv_req,
  input  logic             full_req,
  input  logic             wr_req,
  output logic             pc_os,
  output logic             priv_grant,
  output logic             wr_grant,
  output logic             viol_q
);

  logic attempt;
  logic viol_d;

  assign pc_os      = (pc_bank == '0);
  assign attempt    = priv_req | full_req | wr_req;
  assign viol_d     = attempt & ~pc_os;
  assign priv_grant = priv_req & pc_os;
  assign wr_grant   = wr_req & pc_os;

  always_ff @(posedge clk) begin
    if (!rst_n) viol_q <= 1'b0;
    else        viol_q <= viol_d;
  end

  AST_GRANT_NEEDS_OS: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_grant || wr_grant) |-> (pc_bank == '0)); // R7

  AST_REFUSE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_req && pc_bank != '0) |=> viol_q); // R7

  AST_VIOL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    viol_q |-> $past(pc_bank != '0)); // R6

endmodule

// File: rtl/addr_xlate.sv
module addr_xlate #(
  parameter int PID_W = 8,
  parameter int OFF_W = 16,
  parameter int BANKS = 8,
  localparam int PA_W = PID_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             acc_full,
  input  logic             full_ok,
  input  logic [PA_W-1:0]  acc_addr,
  input  logic [OFF_W-1:0] acc_disp,
  input  logic [PID_W-1:0] cur_pid,
  input  logic             mem_ready,
  output logic             mem_valid,
  output logic [PA_W-1:0]  mem_addr,
  output logic             acc_ready,
  output logic             fault_now
);

  localparam logic [PID_W:0] BANK_CNT = (PID_W + 1)'(BANKS);

  logic [OFF_W-1:0] user_off;
  logic [PA_W-1:0]  full_addr;
  logic [PA_W-1:0]  phys;
  logic [PID_W-1:0] bank;
  logic             bank_over;
  logic             blocked;
  logic             drop;

  // Offset arithmetic stays inside the bank: OFF_W-bit sum, carry discarded.
  assign user_off  = acc_addr[OFF_W-1:0] + acc_disp;
  assign full_addr = acc_addr + PA_W'(acc_disp);
  assign phys      = acc_full ? full_addr : {cur_pid, user_off};
  assign bank      = phys[PA_W-1 -: PID_W];

  generate
    if (BANKS >= (1 << PID_W)) begin : g_all_banks
      assign bank_over = 1'b0;
    end else begin : g_bank_limit
      assign bank_over = ({1'b0, bank} >= BANK_CNT);
    end
  endgenerate

  assign blocked   = acc_valid & acc_full & ~full_ok;
  assign fault_now = acc_valid & ~blocked & bank_over;
  assign drop      = blocked | fault_now;
  assign mem_valid = acc_valid & ~drop;
  assign mem_addr  = phys;
  assign acc_ready = mem_ready | drop;

  AST_BANK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> ({1'b0, mem_addr[PA_W-1 -: PID_W]} < BANK_CNT)); // R9

  AST_USER_OWN_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !acc_full) |-> (mem_addr[PA_W-1 -: PID_W] == cur_pid)); // R2

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |-> !acc_ready); // R10

  AST_STALL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr))); // R10

endmodule

// File: rtl/pid_guard.sv
module pid_guard #(
  parameter int PID_W = 8,
  parameter int OFF_W = 16,
  parameter int BANKS = 8,
  localparam int PA_W = PID_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PID_W-1:0] pc_bank_i,
  input  logic             os_enter_i,
  input  logic             os_return_i,
  input  logic             priv_req_i,
  output logic             priv_grant_o,
  input  logic             pid_wr_i,
  input  logic [PID_W-1:0] pid_wdata_i,
  input  logic             acc_valid_i,
  output logic             acc_ready_o,
  input  logic             acc_full_i,
  input  logic [PA_W-1:0]  acc_addr_i,
  input  logic [OFF_W-1:0] acc_disp_i,
  output logic             mem_valid_o,
  input  logic             mem_ready_i,
  output logic [PA_W-1:0]  mem_addr_o,
  output logic [PID_W-1:0] pid_o,
  output logic             priv_viol_o,
  output logic             bank_fault_o
);

  logic             pc_os;
  logic             wr_grant;
  logic             fault_now;
  logic             fault_q;
  logic [PID_W-1:0] resume_pid;

  priv_check #(.PID_W(PID_W)) u_priv (
    .clk        (clk),
    .rst_n      (rst_n),
    .pc_bank    (pc_bank_i),
    .priv_req   (priv_req_i),
    .full_req   (acc_valid_i & acc_full_i),
    .wr_req     (pid_wr_i),
    .pc_os      (pc_os),
    .priv_grant (priv_grant_o),
    .wr_grant   (wr_grant),
    .viol_q     (priv_viol_o)
  );

  pid_state #(.PID_W(PID_W)) u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .os_enter   (os_enter_i),
    .os_return  (os_return_i),
    .wr_grant   (wr_grant),
    .wr_pid     (pid_wdata_i),
    .cur_pid    (pid_o),
    .resume_pid (resume_pid)
  );

  addr_xlate #(.PID_W(PID_W), .OFF_W(OFF_W), .BANKS(BANKS)) u_xlate (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid_i),
    .acc_full  (acc_full_i),
    .full_ok   (pc_os),
    .acc_addr  (acc_addr_i),
    .acc_disp  (acc_disp_i),
    .cur_pid   (pid_o),
    .mem_ready (mem_ready_i),
    .mem_valid (mem_valid_o),
    .mem_addr  (mem_addr_o),
    .acc_ready (acc_ready_o),
    .fault_now (fault_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) fault_q <= 1'b0;
    else        fault_q <= fault_now;
  end
  assign bank_fault_o = fault_q;

  AST_FULL_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_i && acc_full_i && pc_bank_i != '0) |-> (!mem_valid_o && acc_ready_o)); // R6

  AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_i && !mem_valid_o && !(acc_full_i && pc_bank_i != '0)) |=> bank_fault_o); // R9

  AST_DENIED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (pid_wr_i && pc_bank_i != '0 && !os_enter_i) |=> (resume_pid == $past(resume_pid))); // R6

  AST_FULL_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid_o && acc_full_i) |-> (mem_addr_o == acc_addr_i + PA_W'(acc_disp_i))); // R5

endmodule

// File: tb/pid_guard_bench.sv
module pid_guard_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  pc_bank;
  logic        os_enter, os_return, priv_req, pid_wr;
  logic [7:0]  pid_wdata;
  logic        acc_valid, acc_full, mem_ready;
  logic [23:0] acc_addr;
  logic [15:0] acc_disp;
  logic        priv_grant, acc_ready, mem_valid, priv_viol, bank_fault;
  logic [23:0] mem_addr;
  logic [7:0]  pid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pid_guard u_pid_guard (
    .clk(clk), .rst_n(rst_n), .pc_bank_i(pc_bank),
    .os_enter_i(os_enter), .os_return_i(os_return),
    .priv_req_i(priv_req), .priv_grant_o(priv_grant),
    .pid_wr_i(pid_wr), .pid_wdata_i(pid_wdata),
    .acc_valid_i(acc_valid), .acc_ready_o(acc_ready), .acc_full_i(acc_full),
    .acc_addr_i(acc_addr), .acc_disp_i(acc_disp),
    .mem_valid_o(mem_valid), .mem_ready_i(mem_ready), .mem_addr_o(mem_addr),
    .pid_o(pid), .priv_viol_o(priv_viol), .bank_fault_o(bank_fault)
  );

  typedef struct packed {
    logic [7:0]  pc;
    logic        full;
    logic [23:0] addr;
    logic [15:0] disp;
    logic        ev;
    logic [23:0] ea;
    logic        eviol;
    logic        efault;
  } vec_t;

  // Current ID is 3 while this table runs; memory side always ready.
  localparam vec_t TBL [6] = '{
    '{8'h03, 1'b0, 24'h001234, 16'h0000, 1'b1, 24'h031234, 1'b0, 1'b0},
    '{8'h03, 1'b0, 24'hFFFFF0, 16'h0020, 1'b1, 24'h030010, 1'b0, 1'b0},
    '{8'h03, 1'b1, 24'h001000, 16'h0000, 1'b0, 24'h000000, 1'b1, 1'b0},
    '{8'h00, 1'b1, 24'h05FFFF, 16'h0001, 1'b1, 24'h060000, 1'b0, 1'b0},
    '{8'h00, 1'b1, 24'h0A0000, 16'h0000, 1'b0, 24'h000000, 1'b0, 1'b1},
    '{8'h00, 1'b1, 24'h07ABCD, 16'h0000, 1'b1, 24'h07ABCD, 1'b0, 1'b0}
  };

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic idle();
    pc_bank = 8'h00; os_enter = 0; os_return = 0; priv_req = 0;
    pid_wr = 0; pid_wdata = 8'h00; acc_valid = 0; acc_full = 0;
    acc_addr = '0; acc_disp = '0; mem_ready = 1;
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      report();
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    idle();
    repeat (3) cyc();
    chk("R1 pid at reset", pid, 0);
    chk("R1 viol at reset", priv_viol, 0);
    chk("R1 fault at reset", bank_fault, 0);
    chk("R1 mem_valid at reset", mem_valid, 0);
    rst_n = 1;
    cyc();
    os_return = 1; cyc(); idle();
    chk("R1 return after reset", pid, 0);

    // R8: scheduler picks ID 3 from OS code
    pid_wr = 1; pid_wdata = 8'h03; cyc(); idle();
    chk("R8 pid unchanged by write", pid, 0);
    os_return = 1; cyc(); idle();
    chk("R4 return restores 3", pid, 3);

    for (int i = 0; i < 6; i++) begin
      pc_bank = TBL[i].pc; acc_full = TBL[i].full;
      acc_addr = TBL[i].addr; acc_disp = TBL[i].disp; acc_valid = 1;
      #1;
      chk($sformatf("vector %0d valid (R2 R5 R6 R9)", i), mem_valid, TBL[i].ev);
      if (TBL[i].ev) chk($sformatf("vector %0d addr (R2 R5)", i), mem_addr, TBL[i].ea);
      chk($sformatf("vector %0d ready (R10)", i), acc_ready, 1);
      cyc(); idle();
      chk($sformatf("vector %0d viol (R6)", i), priv_viol, TBL[i].eviol);
      chk($sformatf("vector %0d fault (R9)", i), bank_fault, TBL[i].efault);
    end

    // R7 privileged instruction flag
    pc_bank = 8'h03; priv_req = 1; #1;
    chk("R7 grant refused in user", priv_grant, 0);
    cyc(); idle();
    chk("R7 viol after refusal", priv_viol, 1);
    cyc();
    chk("R6 viol lasts one cycle", priv_viol, 0);
    priv_req = 1; #1;
    chk("R7 grant in OS", priv_grant, 1);
    cyc(); idle();
    chk("R7 no viol when granted", priv_viol, 0);

    // R6 denied ID write from user code
    pc_bank = 8'h03; pid_wr = 1; pid_wdata = 8'h05; cyc(); idle();
    chk("R6 viol on user write", priv_viol, 1);
    os_enter = 1; cyc(); idle();
    chk("R3 entry forces 0", pid, 0);
    os_enter = 1; cyc(); idle();
    chk("R4 nested entry stays 0", pid, 0);
    os_return = 1; cyc(); idle();
    chk("R4 nested return restores 3 (R6 write ignored)", pid, 3);

    // R10 back-pressure
    pc_bank = 8'h03; acc_valid = 1; acc_addr = 24'h000042; mem_ready = 0; #1;
    chk("R10 valid under stall", mem_valid, 1);
    chk("R10 not ready under stall", acc_ready, 0);
    chk("R10 addr under stall", mem_addr, 24'h030042);
    cyc();
    chk("R10 still stalled", acc_ready, 0);
    mem_ready = 1; #1;
    chk("R10 accepted when ready", acc_ready, 1);
    cyc(); idle();

    // R3 entry beats return in the same cycle
    os_enter = 1; os_return = 1; cyc(); idle();
    chk("R3 entry wins over return", pid, 0);

    // R9 user ID beyond installed banks
    pid_wr = 1; pid_wdata = 8'h09; cyc(); idle();
    os_return = 1; cyc(); idle();
    chk("R4 return to ID 9", pid, 9);
    pc_bank = 8'h09; acc_valid = 1; acc_addr = 24'h000010; mem_ready = 0; #1;
    chk("R9 faulted access suppressed", mem_valid, 0);
    chk("R9 faulted access consumed", acc_ready, 1);
    cyc(); idle();
    chk("R9 fault pulse", bank_fault, 1);
    cyc();
    chk("R9 fault pulse ends", bank_fault, 0);

    done = 1'b1;
    report();
    $finish;
  end

endmodule